// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation converter. It drives the trial code of an external DAC, reads back a one-bit comparator decision, and builds the result one bit per conversion-clock cycle, starting at the most significant bit. A conversion can be started in two ways. In manual mode a software start pulse starts it. In auto-sampling mode only the rising edge of a PWM strobe input starts it, so that sampling lines up with the power stage.

Each conversion runs through a fixed series of phases. The first is one conversion-clock cycle of start delay. Next comes a sample-and-hold phase, or an autozero phase when the gain select is set. Then come eight bit decisions, a cycle that writes the result and raises the pending flag, and a final cycle after which busy drops. Because the pending flag rises one conversion-clock cycle before busy clears, software must use the busy flag to tell when the converter is idle again. The conversion clock is a one-cycle enable taken from the system clock. A speed field chooses a divide of 1, 2, 4 or 8.

While a conversion runs, every start request is dropped. Writes to the configuration are also refused in that time. The pending flag stays set until software writes a one to clear it. The interrupt request is the pending flag gated by the interrupt enable.

Top module: `sar_conv_seq`

## Requirements
- R1: In manual mode (cfgAuto register 0), a swStart pulse while idle is accepted at that clock edge, and busy reads 1 in the next cycle.
- R2: In auto-sampling mode (cfgAuto register 1), swStart is ignored. Only a 0-to-1 transition of pwmStrobe while idle starts a conversion, so a strobe held high starts at most one conversion.
- R3: Any start request (swStart or a strobe rise) that arrives while busy is dropped. It neither restarts nor lengthens the running conversion and does not queue a second one.
- R4: The first conversion-clock cycle after acceptance is a delay, with holdPhase and zeroPhase both 0. The next cycle is the first phase: zeroPhase=1 if the gain register is 1, otherwise holdPhase=1.
- R5: The bits are decided from MSB to LSB. The first trial code is 0x80. A trial bit is kept when cmpIn=1 (input at or above the trial code). The final result is the largest code that the comparator accepts.
- R6: The pending flag is set in the same cycle that the result register is written, while busy is still 1. irq is 1 exactly when pending=1 and irqEn=1.
- R7: busy clears one conversion-clock cycle after pending is set. A conversion keeps busy high for 12 conversion-clock cycles in total.
- R8: A speed register value s gives one conversion-clock enable every 2^s system clocks, so busy stays high for 12*2^s system clock cycles.
- R9: A configuration write (cfgWrEn with gain, speed, auto) takes effect when idle and is ignored while busy.
- R10: pending stays 1 until pendClr=1 is applied. If a result is written in the same cycle as a clear, pending stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the configuration registers |
| cfgGain | input | 1 | Gain select: 1 gives an autozero first phase |
| cfgSpeed | input | 2 | Conversion-clock divide select (2^value) |
| cfgAuto | input | 1 | Auto-sampling mode select |
| swStart | input | 1 | Software start pulse (manual mode) |
| pwmStrobe | input | 1 | PWM strobe, rising edge starts in auto mode |
| cmpIn | input | 1 | Comparator decision: input at or above trial code |
| pendClr | input | 1 | Write-one clear of the pending flag |
| irqEn | input | 1 | Interrupt enable |
| dacCode | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Last conversion result |
| holdPhase | output | 1 | Sample-and-hold phase active |
| zeroPhase | output | 1 | Autozero phase active |
| busy | output | 1 | Conversion in progress |
| pending | output | 1 | Result-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The comparator is modelled as a test that the chosen input code is at least the trial code. Conversions are run at the extreme codes 0x00 and 0xFF, at the alternating patterns 0xA5 and 0x5A, and at the neighbours 0x80 and 0x7F. These separate a wrong bit order, a stuck trial bit and an off-by-one in the final decision. The same conversions are repeated at every speed value, and busy is measured each time, which shows whether the phase count and the divide factor are right. Extra start pulses and strobe edges are injected in the middle of a conversion. A configuration write is made while busy. The strobe is held high through completion. A pending clear is made to coincide with the result write. Each of these must leave the measured duration, the phase outputs and the flags as they would be without the extra stimulus.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAR_W   = 8;
  localparam int IDX_W   = $clog2(SAR_W);
  localparam int SPEED_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_PHASE,
    ST_BIT,
    ST_WRITE,
    ST_DONE
  } seqState_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic             initTrial;
    logic             decide;
    logic             inBits;
    logic [IDX_W-1:0] bitIdx;
    logic             writeRes;
  } seqStrobe_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int SPEED_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic [SPEED_W-1:0] speed,
  output logic               tick
);
  localparam int CNT_W = (1 << SPEED_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim;

  always_comb begin
    span = (CNT_W+1)'(1) << speed;
    lim  = CNT_W'(span - (CNT_W+1)'(1));
    tick = run && (cnt == lim);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               cfgWrEn,
  input  logic               cfgGain,
  input  logic [SPEED_W-1:0] cfgSpeed,
  input  logic               cfgAuto,
  input  logic               swStart,
  input  logic               strobeRise,
  output logic               gainQ,
  output logic [SPEED_W-1:0] speedQ,
  output logic               autoQ,
  output logic               busy,
  output logic               holdPhase,
  output logic               zeroPhase,
  output seqStrobe_t         stb
);
  seqState_t        state;
  logic [IDX_W-1:0] bitIdx;
  logic             trig;

  always_comb begin
    trig          = (state == ST_IDLE) && (autoQ ? strobeRise : swStart);
    busy          = (state != ST_IDLE);
    holdPhase     = (state == ST_PHASE) && !gainQ;
    zeroPhase     = (state == ST_PHASE) && gainQ;
    stb.initTrial = (state == ST_PHASE) && tick;
    stb.decide    = (state == ST_BIT) && tick;
    stb.inBits    = (state == ST_BIT);
    stb.bitIdx    = bitIdx;
    stb.writeRes  = (state == ST_WRITE) && tick;
  end

  // configuration is locked while a conversion runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainQ  <= 1'b0;
      speedQ <= '0;
      autoQ  <= 1'b0;
    end else if (cfgWrEn && (state == ST_IDLE)) begin
      gainQ  <= cfgGain;
      speedQ <= cfgSpeed;
      autoQ  <= cfgAuto;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (trig) state <= ST_DELAY;
        ST_DELAY: if (tick) state <= ST_PHASE;
        ST_PHASE: if (tick) begin
          state  <= ST_BIT;
          bitIdx <= IDX_W'(SAR_W - 1);
        end
        ST_BIT: if (tick) begin
          if (bitIdx == '0) state <= ST_WRITE;
          else              bitIdx <= bitIdx - IDX_W'(1);
        end
        ST_WRITE: if (tick) state <= ST_DONE;
        ST_DONE:  if (tick) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_dp.sv
module sar_dp
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic             cmpIn,
  input  logic             pendClr,
  input  logic             irqEn,
  output logic [SAR_W-1:0] dacCode,
  output logic [SAR_W-1:0] result,
  output logic             pending,
  output logic             irq
);
  logic [SAR_W-1:0] acc;
  logic [SAR_W-1:0] trialBit;

  always_comb begin
    trialBit = '0;
    trialBit[stb.bitIdx] = 1'b1;
    dacCode  = stb.inBits ? (acc | trialBit) : acc;
    irq      = pending && irqEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       acc <= '0;
    else if (stb.initTrial)          acc <= '0;
    else if (stb.decide && cmpIn)    acc <= acc | trialBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (stb.writeRes) result <= acc;
  end

  // new completion takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pending <= 1'b0;
    else if (stb.writeRes) pending <= 1'b1;
    else if (pendClr)      pending <= 1'b0;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgGain,
  input  logic [SPEED_W-1:0] cfgSpeed,
  input  logic               cfgAuto,
  input  logic               swStart,
  input  logic               pwmStrobe,
  input  logic               cmpIn,
  input  logic               pendClr,
  input  logic               irqEn,
  output logic [SAR_W-1:0]   dacCode,
  output logic [SAR_W-1:0]   result,
  output logic               holdPhase,
  output logic               zeroPhase,
  output logic               busy,
  output logic               pending,
  output logic               irq
);
  logic               strobeQ;
  logic               strobeRise;
  logic               tick;
  logic               gainQ;
  logic               autoQ;
  logic [SPEED_W-1:0] speedQ;
  logic               pendSet;
  seqStrobe_t         seqStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeQ <= 1'b0;
    else       strobeQ <= pwmStrobe;
  end

  assign strobeRise = pwmStrobe && !strobeQ;
  assign pendSet    = seqStb.writeRes;

  sar_clkdiv #(.SPEED_W(SPEED_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .run   (busy),
    .speed (speedQ),
    .tick  (tick)
  );

  sar_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .cfgWrEn    (cfgWrEn),
    .cfgGain    (cfgGain),
    .cfgSpeed   (cfgSpeed),
    .cfgAuto    (cfgAuto),
    .swStart    (swStart),
    .strobeRise (strobeRise),
    .gainQ      (gainQ),
    .speedQ     (speedQ),
    .autoQ      (autoQ),
    .busy       (busy),
    .holdPhase  (holdPhase),
    .zeroPhase  (zeroPhase),
    .stb        (seqStb)
  );

  sar_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (seqStb),
    .cmpIn   (cmpIn),
    .pendClr (pendClr),
    .irqEn   (irqEn),
    .dacCode (dacCode),
    .result  (result),
    .pending (pending),
    .irq     (irq)
  );
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk
  import sar_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               swStart,
  input logic               pwmStrobe,
  input logic               strobeQ,
  input logic               cfgWrEn,
  input logic               pendClr,
  input logic               busy,
  input logic               pending,
  input logic               pendSet,
  input logic               autoQ,
  input logic               gainQ,
  input logic [SPEED_W-1:0] speedQ
);
  logic busyQ;
  logic pendSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      pendSeen <= 1'b0;
    end else begin
      busyQ <= busy;
      if (busy && !busyQ)        pendSeen <= 1'b0;
      else if (busy && pending)  pendSeen <= 1'b1;
    end
  end

  p_sw_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && swStart && !autoQ) |=> busy);

  p_sw_ignored_auto_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && autoQ && swStart && !(pwmStrobe && !strobeQ)) |=> !busy);

  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgWrEn) |=> ($stable(speedQ) && $stable(gainQ) && $stable(autoQ)));

  p_pend_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> busy);

  p_pend_before_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> pendSeen);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendSet && pendClr) |=> pending);
endmodule

bind sar_conv_seq sar_conv_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swStart   (swStart),
  .pwmStrobe (pwmStrobe),
  .strobeQ   (strobeQ),
  .cfgWrEn   (cfgWrEn),
  .pendClr   (pendClr),
  .busy      (busy),
  .pending   (pending),
  .pendSet   (pendSet),
  .autoQ     (autoQ),
  .gainQ     (gainQ),
  .speedQ    (speedQ)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PH_TICKS   = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0, cfgGain = 1'b0, cfgAuto = 1'b0;
  logic [1:0] cfgSpeed = 2'd0;
  logic       swStart = 1'b0, pwmStrobe = 1'b0, pendClr = 1'b0, irqEn = 1'b0;
  logic       cmpIn;
  logic [7:0] dacCode, result;
  logic       holdPhase, zeroPhase, busy, pending, irq;
  logic [7:0] vin = 8'd0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int code;
    int dur;
    bit chkPend;
    bit irqExp;
  } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: input at or above trial code
  assign cmpIn = (vin >= dacCode);

  sar_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgGain(cfgGain),
    .cfgSpeed(cfgSpeed), .cfgAuto(cfgAuto), .swStart(swStart),
    .pwmStrobe(pwmStrobe), .cmpIn(cmpIn), .pendClr(pendClr), .irqEn(irqEn),
    .dacCode(dacCode), .result(result), .holdPhase(holdPhase),
    .zeroPhase(zeroPhase), .busy(busy), .pending(pending), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: measures busy length and pops expectations at busy fall
  int  busyCnt = 0;
  logic prevBusy = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCnt++;
      if (prevBusy && !busy) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected conversion", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(result == it.code[7:0], "R5 result", int'(result), it.code);
          chk(busyCnt == it.dur, "R8 busy length", busyCnt, it.dur);
          if (it.chkPend) begin
            chk(pending == 1'b1, "R6 pending at idle", int'(pending), 1);
            chk(irq == it.irqExp, "R6 irq", int'(irq), int'(it.irqExp));
          end
        end
        busyCnt = 0;
      end
      prevBusy = busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  task automatic cfgWrite(input bit gain, input int speed, input bit auto_);
    cfgGain = gain; cfgSpeed = 2'(speed); cfgAuto = auto_; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearPend();
    pendClr = 1'b1;
    @(negedge clk);
    pendClr = 1'b0;
    chk(pending == 1'b0, "R10 clear", int'(pending), 0);
  endtask

  // driver: start by software and queue the expectation; returns at n1
  task automatic swConv(input int code, input int speed, input bit chkP);
    expItem_t it;
    vin = 8'(code);
    it.code = code; it.dur = PH_TICKS << speed; it.chkPend = chkP; it.irqExp = irqEn;
    expQ.push_back(it);
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && pending == 1'b0, "R1 reset idle", int'(busy), 0);
    chk(result == 8'd0 && dacCode == 8'd0, "R5 reset data", int'(result), 0);
    chk(irq == 1'b0, "R6 reset irq", int'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);

    // phase sequence, gain 0
    cfgWrite(1'b0, 0, 1'b0);
    swConv(8'hA5, 0, 1'b1);
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(holdPhase == 1'b0 && zeroPhase == 1'b0, "R4 delay cycle", int'(holdPhase), 0);
    @(negedge clk);
    chk(holdPhase == 1'b1 && zeroPhase == 1'b0, "R4 sample phase", int'(holdPhase), 1);
    @(negedge clk);
    chk(dacCode == 8'h80, "R5 first trial", int'(dacCode), 128);
    repeat (9) @(negedge clk);
    chk(pending == 1'b1 && busy == 1'b1, "R7 pending before idle", int'(busy), 1);
    waitIdle();
    clearPend();

    // gain 1: autozero phase
    cfgWrite(1'b1, 0, 1'b0);
    swConv(8'h3C, 0, 1'b1);
    @(negedge clk);
    chk(zeroPhase == 1'b1 && holdPhase == 1'b0, "R4 autozero phase", int'(zeroPhase), 1);
    waitIdle();
    clearPend();

    // code patterns, irq alternating
    cfgWrite(1'b0, 0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      int codes[6] = '{8'h00, 8'hFF, 8'h5A, 8'h80, 8'h7F, 8'h01};
      irqEn = i[0];
      swConv(codes[i], 0, 1'b1);
      waitIdle();
      clearPend();
      chk(irq == 1'b0, "R6 irq after clear", int'(irq), 0);
    end
    irqEn = 1'b1;

    // speeds
    for (int s = 1; s < 4; s++) begin
      cfgWrite(1'b0, s, 1'b0);
      swConv(8'h96 + s, s, 1'b1);
      waitIdle();
      clearPend();
    end

    // config write while busy is ignored (R9)
    cfgWrite(1'b0, 0, 1'b0);
    swConv(8'h4D, 0, 1'b1);
    cfgGain = 1'b1; cfgSpeed = 2'd3; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    waitIdle();
    clearPend();
    swConv(8'hB2, 0, 1'b1);
    @(negedge clk);
    chk(holdPhase == 1'b1, "R9 gain unchanged", int'(holdPhase), 1);
    waitIdle();
    clearPend();

    // software retrigger while busy (R3)
    swConv(8'hC3, 0, 1'b1);
    repeat (4) @(negedge clk);
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    waitIdle();
    clearPend();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R3 no queued start", int'(busy), 0);

    // auto-sampling mode (R2)
    cfgWrite(1'b0, 1, 1'b1);
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2 swStart ignored", int'(busy), 0);
    begin
      expItem_t it;
      vin = 8'h69;
      it.code = 8'h69; it.dur = PH_TICKS << 1; it.chkPend = 1'b1; it.irqExp = 1'b1;
      expQ.push_back(it);
    end
    pwmStrobe = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 strobe start", int'(busy), 1);
    repeat (3) @(negedge clk);
    pwmStrobe = 1'b0;
    repeat (2) @(negedge clk);
    pwmStrobe = 1'b1;
    waitIdle();
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R2 held strobe no restart", int'(busy), 0);
    clearPend();
    pwmStrobe = 1'b0;
    @(negedge clk);
    begin
      expItem_t it;
      vin = 8'hE7;
      it.code = 8'hE7; it.dur = PH_TICKS << 1; it.chkPend = 1'b1; it.irqExp = 1'b1;
      expQ.push_back(it);
    end
    pwmStrobe = 1'b1;
    @(negedge clk);
    pwmStrobe = 1'b0;
    waitIdle();
    clearPend();

    // set wins over clear (R10)
    cfgWrite(1'b0, 0, 1'b0);
    pendClr = 1'b1;
    swConv(8'h2B, 0, 1'b0);
    repeat (11) @(negedge clk);
    chk(pending == 1'b1, "R10 set wins", int'(pending), 1);
    waitIdle();
    pendClr = 1'b0;
    chk(pending == 1'b0, "R10 held clear", int'(pending), 0);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3 all conversions seen", expQ.size(), 0);
    finishRun();
  end
endmodule